// File: doc/BRIEF.md
# Address Acknowledge Timing Controller

This block sits in a memory-controller slave on a split-transaction processor bus, where address and data phases overlap. It decides the clock in which the slave drives its active-low address acknowledge. Address decoding, arbitration and the data path are handled elsewhere and arrive here as single-cycle strobes. The block observes every accepted address tenure on the bus and learns from each whether it selected this slave, whether it carries data and whether that data is a four-beat burst or a single beat. It also counts data-beat strobes so that it knows when the data tenure in progress ends.

When no data tenure is in progress, an address tenure that selects this slave is acknowledged in the next clock. When a data tenure is still open, the acknowledge waits for that tenure's final beat. If this slave owns the open tenure, the acknowledge shares the clock of the final beat. If another agent owns it, the acknowledge comes one clock later. The data tenure of an address accepted behind an open one is held in a one-entry queue. The queued tenure becomes the open tenure once the earlier one closes.

Top module: `addr_ack_timer`

## Requirements
- R1: An address tenure with addr_hit low is never acknowledged; ack_n stays high for it.
- R2: An address tenure that selects this slave, accepted while no data tenure is open, drives ack_n low in the following clock.
- R3: An address tenure that selects this slave, accepted while a data tenure owned by this slave is open, drives ack_n low in the same clock as that tenure's final beat_valid.
- R4: An address tenure that selects this slave, accepted while a data tenure owned by another agent is open, drives ack_n low in the clock after that tenure's final beat_valid.
- R5: Every acknowledged address tenure holds ack_n low for exactly one clock.
- R6: A data tenure opened with addr_burst=1 ends on its 4th beat_valid and one opened with addr_burst=0 ends on its 1st. beat_valid has no effect while no data tenure is open.
- R7: An address tenure with addr_only=1 opens no data tenure, so a later address tenure is treated as if nothing were open.
- R8: data_queued is high from the clock after a data-carrying address tenure is accepted behind an open data tenure. It falls in the clock after that open tenure's final beat, when the queued tenure becomes the open one.
- R9: An address tenure accepted in the same clock as the final beat of the open data tenure is treated as having no data tenure outstanding.
- R10: addr_valid is ignored (no acknowledge, nothing opened or queued) while a data tenure is queued or an acknowledge is still waiting.
- R11: While rst_n is low at a clock edge, all tenure state is cleared, ack_n goes high and data_queued goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_valid | input | 1 | An address tenure is accepted on the bus this clock |
| addr_hit | input | 1 | The accepted address tenure selects this slave |
| addr_only | input | 1 | The accepted address tenure has no data phase |
| addr_burst | input | 1 | The accepted tenure's data is a four-beat burst (else one beat) |
| beat_valid | input | 1 | A data beat of the open data tenure is on the bus this clock |
| ack_n | output | 1 | Address acknowledge, active low |
| data_queued | output | 1 | The data tenure of an accepted address waits behind an open one |

## Verification
The main function is tried with addresses that arrive on an idle data bus, behind a data tenure that this slave owns, and behind one that another agent owns. Comparing these three cases separates the immediate, coincident and one-clock-late acknowledge. Bursts with idle gaps between beats check that the final beat comes from counting strobes and not from elapsed clocks. Address-only tenures, an address in the same clock as a final beat, an address offered while the queue is full, stray beats and a reset in mid-transfer each show a case where the acknowledge must or must not be issued.

// File: rtl/addr_ack_timer.sv
module addr_ack_timer #(
  parameter int BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_valid,
  input  logic addr_hit,
  input  logic addr_only,
  input  logic addr_burst,
  input  logic beat_valid,
  output logic ack_n,
  output logic data_queued
);
  localparam int CW = $clog2(BURST_BEATS + 1);
  localparam logic [CW-1:0] BURST_LAST = CW'(BURST_BEATS - 1);

  logic          open_v, open_own, open_burst;
  logic [CW-1:0] beat_cnt;
  logic          q_v, q_own, q_burst;
  logic          pnd_v;
  logic          ack_q;

  logic last_beat, busy, take, has_data, ack_now;

  assign last_beat = open_v & beat_valid &
                     (beat_cnt == (open_burst ? BURST_LAST : '0));
  assign busy      = open_v & ~last_beat;
  assign take      = addr_valid & ~q_v & ~pnd_v;
  assign has_data  = ~addr_only;
  assign ack_now   = pnd_v & open_own & last_beat;

  assign ack_n       = ~(ack_q | ack_now);
  assign data_queued = q_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v     <= 1'b0;
      open_own   <= 1'b0;
      open_burst <= 1'b0;
      beat_cnt   <= '0;
      q_v        <= 1'b0;
      q_own      <= 1'b0;
      q_burst    <= 1'b0;
      pnd_v      <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= (take & addr_hit & ~busy) | (pnd_v & ~open_own & last_beat);

      if (pnd_v & last_beat)
        pnd_v <= 1'b0;
      else if (take & addr_hit & busy)
        pnd_v <= 1'b1;

      if (last_beat) begin
        beat_cnt <= '0;
        if (q_v) begin
          open_v     <= 1'b1;
          open_own   <= q_own;
          open_burst <= q_burst;
        end else if (take & has_data) begin
          open_v     <= 1'b1;
          open_own   <= addr_hit;
          open_burst <= addr_burst;
        end else begin
          open_v <= 1'b0;
        end
      end else if (take & has_data & ~open_v) begin
        open_v     <= 1'b1;
        open_own   <= addr_hit;
        open_burst <= addr_burst;
        beat_cnt   <= '0;
      end else if (open_v & beat_valid) begin
        beat_cnt <= beat_cnt + CW'(1);
      end

      if (last_beat)
        q_v <= 1'b0;
      else if (take & has_data & busy) begin
        q_v     <= 1'b1;
        q_own   <= addr_hit;
        q_burst <= addr_burst;
      end
    end
  end
endmodule

// File: rtl/addr_ack_timer_chk.sv
module addr_ack_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_valid,
  input logic addr_hit,
  input logic ack_n,
  input logic data_queued,
  input logic open_v,
  input logic open_own,
  input logic pnd_v,
  input logic q_v,
  input logic last_beat
);
  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> (ack_n && !data_queued));

  p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_hit && !pnd_v && !q_v && !(open_v && !last_beat)) |=> !ack_n);

  p_own_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_v && open_own && last_beat) |-> !ack_n);

  p_wait_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_v |-> open_v);

  p_foreign_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_v && !open_own && last_beat) |=> !ack_n);

  p_ack_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> ($past(addr_valid && addr_hit) || (pnd_v && last_beat) ||
                $past(pnd_v && last_beat)));

  p_queue_behind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_queued |-> open_v);
endmodule

bind addr_ack_timer addr_ack_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_hit(addr_hit),
  .ack_n(ack_n), .data_queued(data_queued), .open_v(open_v),
  .open_own(open_own), .pnd_v(pnd_v), .q_v(q_v), .last_beat(last_beat)
);

// File: tb/addr_ack_timer_tb.sv
module addr_ack_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 45;
  // {addr_valid, addr_hit, addr_only, addr_burst, beat_valid, exp_ack_n, exp_queued}
  localparam logic [6:0] VEC [NV] = '{
    7'b00000_1_0, // 0 idle
    7'b11000_1_0, // 1 own single, idle bus
    7'b00000_0_0, // 2 R2 ack next clock
    7'b00001_1_0, // 3 last beat of single
    7'b10010_1_0, // 4 foreign burst opens, R1
    7'b11000_1_0, // 5 own single behind foreign
    7'b00001_1_1, // 6 beat 1, R8 queued
    7'b00001_1_1, // 7 beat 2
    7'b00000_1_1, // 8 gap, R6
    7'b00001_1_1, // 9 beat 3
    7'b00001_1_1, // 10 beat 4 (last)
    7'b00000_0_0, // 11 R4 ack one clock late
    7'b11010_1_0, // 12 own burst behind own single
    7'b00000_1_1, // 13
    7'b00001_0_1, // 14 R3 ack with last beat
    7'b00000_1_0, // 15 R5 one clock only
    7'b10100_1_0, // 16 foreign addr-only, R1
    7'b00001_1_0, // 17
    7'b00001_1_0, // 18
    7'b00001_1_0, // 19
    7'b11101_1_0, // 20 R9 own addr-only on last beat
    7'b00000_0_0, // 21 immediate ack
    7'b11000_1_0, // 22 R7 nothing open
    7'b00000_0_0, // 23
    7'b10000_1_0, // 24 foreign single queued
    7'b11000_1_1, // 25 R10 ignored
    7'b00001_1_1, // 26 own single ends, no ack
    7'b00001_1_0, // 27 foreign single ends
    7'b00000_1_0, // 28 still no ack, R10
    7'b11000_1_0, // 29
    7'b00000_0_0, // 30
    7'b00001_1_0, // 31
    7'b00001_1_0, // 32 stray beat, R6
    7'b11000_1_0, // 33
    7'b00000_0_0, // 34
    7'b00001_1_0, // 35
    7'b11010_1_0, // 36 own burst, idle
    7'b11000_0_0, // 37 own single behind own burst
    7'b00001_1_1, // 38
    7'b00001_1_1, // 39
    7'b00001_1_1, // 40
    7'b00001_0_1, // 41 R3 R6 fourth beat
    7'b00000_1_0, // 42
    7'b00001_1_0, // 43
    7'b00000_1_0  // 44
  };

  logic clk = 1'b0;
  logic rst_n, addr_valid, addr_hit, addr_only, addr_burst, beat_valid;
  logic ack_n, data_queued;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  addr_ack_timer u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_hit(addr_hit),
    .addr_only(addr_only), .addr_burst(addr_burst), .beat_valid(beat_valid),
    .ack_n(ack_n), .data_queued(data_queued)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [4:0] s);
    @(negedge clk);
    {addr_valid, addr_hit, addr_only, addr_burst, beat_valid} = s;
    #(CLK_PERIOD/2 - 1);
  endtask

  task automatic check(input string req, input logic a, input logic q,
                       input logic ea, input logic eq);
    checks++;
    if (a !== ea || q !== eq) begin
      failures++;
      $display("FAIL %s: ack_n=%b data_queued=%b expected ack_n=%b data_queued=%b",
               req, a, q, ea, eq);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(5'b0);
    drive(5'b0);
    check("R11 reset state", ack_n, data_queued, 1'b1, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6:2]);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 row %0d", i),
            ack_n, data_queued, VEC[i][1], VEC[i][0]);
    end
    // R11 reset in mid-transfer clears the open and queued tenures
    drive(5'b10010);
    drive(5'b11000);
    drive(5'b00001);
    check("R8 queued before reset", ack_n, data_queued, 1'b1, 1'b1);
    rst_n = 1'b0;
    drive(5'b00000);
    check("R11 reset clears queue", ack_n, data_queued, 1'b1, 1'b0);
    rst_n = 1'b1;
    drive(5'b11000);
    check("R11 no stale pending", ack_n, data_queued, 1'b1, 1'b0);
    drive(5'b00000);
    check("R11 R2 immediate after reset", ack_n, data_queued, 1'b0, 1'b0);
    drive(5'b00000);
    check("R5 single clock ack", ack_n, data_queued, 1'b1, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(CLK_PERIOD * 2000);
    join_any
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule